// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Group

This block collects up to ten interrupt causes into a status register and produces one level interrupt toward the processor. Hardware event inputs set cause bits. Software clears a cause by writing a one to its bit. Software cannot write the mask directly. It uses three command addresses instead: one unmasks sources, one masks sources, and one forces causes so that the interrupt path can be exercised without hardware. The mask leaves reset with every source blocked.

The same register port also carries a small control word. When software writes that word with its scan request bit set, the block records scan completion and scan success in a read-only configuration status word. A completion flag in that status word is set from reset. Access is through a plain word-addressed read/write port. Reads are combinational, and a write takes effect at the clock edge on which it is presented.

Top module: `irq_regfile`

## Requirements
- R1: The cause register at word address 0 holds one bit per source in bits [9:0]. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. Bits 31:10 always read as zero, and a write to any address sets no bit above bit 9.
- R2: A high hardware event input sets its cause bit at the next clock edge. When that edge also carries a software clear of the same bit, the set wins.
- R3: Writing the force command at word address 4 sets every cause bit whose data bit is 1, and leaves the other cause bits unchanged.
- R4: The mask at word address 1 reads 0x3FF after reset. A write to address 1 does not change it.
- R5: Writing the unmask command at word address 2 clears each mask bit whose data bit is 1, and leaves the other mask bits unchanged.
- R6: Writing the mask command at word address 3 sets each mask bit whose data bit is 1, and leaves the other mask bits unchanged.
- R7: Reads of addresses 2, 3 and 4, and of the unused address 7, return zero.
- R8: `irq` is a register. It goes high on the clock edge after any cause bit is set while its mask bit is clear, and it goes low on the edge after no such bit remains.
- R9: The control word at word address 5 stores data bits [14:0], and those bits read back. A write with data bit 0 set sets bit 1 (scan done) and bit 2 (scan passed) of the configuration status word at word address 6. A write with data bit 0 clear leaves those two bits unchanged.
- R10: After reset the configuration status word reads 0x1: bit 0 (completion) is set, and bits 1 and 2 are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| hw_event | input | 10 | Per-source hardware cause inputs |
| irq | output | 1 | Registered level interrupt |

## Verification
The one real collision in this block is a hardware event setting a cause bit on the same edge that software writes a one to clear that bit. A directed step clears two causes while an event hits one of them; it expects that bit to survive and the other bit to clear. The random phase mixes sparse event bursts with cause-register writes, so the collision recurs on many bits. After every edge the bench model applies the clear first and the event second, and then compares the cause register and `irq` with the model.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_STATUS  = 3'd0,
      RA_MASK    = 3'd1,
      RA_ENABLE  = 3'd2,
      RA_DISABLE = 3'd3,
      RA_TRIGGER = 3'd4,
      RA_CONTROL = 3'd5,
      RA_CFGSTAT = 3'd6
   } reg_addr_e;

   localparam int CFG_W     = 3;
   localparam int CFG_CMPL  = 0;
   localparam int CFG_DONE  = 1;
   localparam int CFG_PASS  = 2;
endpackage

// File: rtl/irqr_status_bank.sv
module irqr_status_bank #(
   parameter int N_SRC = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_vec,
   input  logic [N_SRC-1:0] clr_vec,
   output logic [N_SRC-1:0] status
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          status[i] <= 1'b0;
         else if (set_vec[i]) status[i] <= 1'b1;
         else if (clr_vec[i]) status[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqr_mask_bank.sv
module irqr_mask_bank #(
   parameter int N_SRC = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] unmask_vec,
   input  logic [N_SRC-1:0] mask_vec,
   output logic [N_SRC-1:0] mask
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             mask[i] <= 1'b1;
         else if (mask_vec[i])   mask[i] <= 1'b1;
         else if (unmask_vec[i]) mask[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqr_scan_ctrl.sv
module irqr_scan_ctrl
   import irqr_pkg::*;
#(
   parameter int CTL_W    = 15,
   parameter int SCAN_BIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_q,
   output logic [CFG_W-1:0] cfg_q
);
   localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(1) << CFG_CMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cfg_q <= CFG_RST;
      end else if (ctl_wr) begin
         ctl_q <= ctl_wdata;
         if (ctl_wdata[SCAN_BIT]) begin
            cfg_q[CFG_DONE] <= 1'b1;
            cfg_q[CFG_PASS] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
   import irqr_pkg::*;
#(
   parameter int N_SRC    = 10,
   parameter int DATA_W   = 32,
   parameter int CTL_W    = 15,
   parameter int SCAN_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_SRC-1:0]  hw_event,
   output logic              irq
);
   if (N_SRC < 1 || N_SRC > DATA_W) begin : g_bad_nsrc
      $error("irq_regfile: N_SRC must lie in 1..DATA_W");
   end
   if (CTL_W < 1 || CTL_W > DATA_W) begin : g_bad_ctlw
      $error("irq_regfile: CTL_W must lie in 1..DATA_W");
   end
   if (SCAN_BIT >= CTL_W) begin : g_bad_scan
      $error("irq_regfile: SCAN_BIT must be below CTL_W");
   end
   if (CFG_W > DATA_W) begin : g_bad_cfg
      $error("irq_regfile: config status wider than data path");
   end

   localparam logic [N_SRC-1:0] NO_SRC = '0;

   logic             wr_status, wr_enable, wr_disable, wr_trigger, wr_control;
   logic [N_SRC-1:0] wsrc;
   logic [N_SRC-1:0] status_q, mask_q;
   logic [CTL_W-1:0] ctl_q;
   logic [CFG_W-1:0] cfg_q;
   logic             unused_wdata;

   assign wr_status  = reg_wr && (reg_addr == RA_STATUS);
   assign wr_enable  = reg_wr && (reg_addr == RA_ENABLE);
   assign wr_disable = reg_wr && (reg_addr == RA_DISABLE);
   assign wr_trigger = reg_wr && (reg_addr == RA_TRIGGER);
   assign wr_control = reg_wr && (reg_addr == RA_CONTROL);
   assign wsrc       = reg_wdata[N_SRC-1:0];
   assign unused_wdata = ^reg_wdata;

   irqr_status_bank #(.N_SRC(N_SRC)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (hw_event | (wr_trigger ? wsrc : NO_SRC)),
      .clr_vec (wr_status ? wsrc : NO_SRC),
      .status  (status_q)
   );

   irqr_mask_bank #(.N_SRC(N_SRC)) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .unmask_vec (wr_enable  ? wsrc : NO_SRC),
      .mask_vec   (wr_disable ? wsrc : NO_SRC),
      .mask       (mask_q)
   );

   irqr_scan_ctrl #(.CTL_W(CTL_W), .SCAN_BIT(SCAN_BIT)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (wr_control),
      .ctl_wdata (reg_wdata[CTL_W-1:0]),
      .ctl_q     (ctl_q),
      .cfg_q     (cfg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(status_q & ~mask_q);
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_STATUS:  reg_rdata[N_SRC-1:0] = status_q;
         RA_MASK:    reg_rdata[N_SRC-1:0] = mask_q;
         RA_CONTROL: reg_rdata[CTL_W-1:0] = ctl_q;
         RA_CFGSTAT: reg_rdata[CFG_W-1:0] = cfg_q;
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_regfile_chk.sv
module irq_regfile_chk
   import irqr_pkg::*;
#(
   parameter int N_SRC    = 10,
   parameter int DATA_W   = 32,
   parameter int CTL_W    = 15,
   parameter int SCAN_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [N_SRC-1:0]  hw_event,
   input logic              irq,
   input logic [N_SRC-1:0]  status_q,
   input logic [N_SRC-1:0]  mask_q,
   input logic [CFG_W-1:0]  cfg_q
);
   // R1: reserved status bits never read as one
   assert_status_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_STATUS) |-> ((reg_rdata >> N_SRC) == '0));

   // R2: an event bit is present in the status on the following cycle
   assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_event) |=> ((status_q & $past(hw_event)) == $past(hw_event)));

   // R3: new status bits come only from events or a force write
   assert_set_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q) & ~$past(hw_event)
        & ~($past(reg_wr && reg_addr == RA_TRIGGER) ? $past(reg_wdata[N_SRC-1:0]) : '0)) == '0));

   // R4: mask moves only after an unmask or mask command
   assert_mask_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && (reg_addr == RA_ENABLE || reg_addr == RA_DISABLE)) |=> $stable(mask_q));

   // R7: command addresses read zero
   assert_cmd_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_ENABLE || reg_addr == RA_DISABLE || reg_addr == RA_TRIGGER)
      |-> (reg_rdata == '0));

   // R8: a pending unmasked cause raises irq one cycle later
   assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status_q & ~mask_q)) |=> irq);

   // R8: nothing pending drops irq one cycle later
   assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status_q & ~mask_q)) |=> !irq);

   // R9: scan request marks done and passed
   assert_scan_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == RA_CONTROL && reg_wdata[SCAN_BIT])
      |=> (cfg_q[CFG_DONE] && cfg_q[CFG_PASS]));

   // R10: completion flag never drops while out of reset
   assert_cmpl_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[CFG_CMPL]);
endmodule

bind irq_regfile irq_regfile_chk #(
   .N_SRC(N_SRC), .DATA_W(DATA_W), .CTL_W(CTL_W), .SCAN_BIT(SCAN_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .hw_event  (hw_event),
   .irq       (irq),
   .status_q  (status_q),
   .mask_q    (mask_q),
   .cfg_q     (cfg_q)
);

// File: tb/tb_irq_regfile.sv
module tb_irq_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 10;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_wr;
   logic [2:0]    reg_addr;
   logic [DW-1:0] reg_wdata;
   logic [DW-1:0] reg_rdata;
   logic [N-1:0]  hw_event;
   logic          irq;

   irq_regfile dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_event(hw_event), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [N-1:0] m_st, m_mk;
   logic [14:0]  m_ctl;
   logic [2:0]   m_cfg;
   logic         m_irq;
   int n_vec = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [2:0] a);
      case (a)
         3'd0:    return {22'b0, m_st};
         3'd1:    return {22'b0, m_mk};
         3'd5:    return {17'b0, m_ctl};
         3'd6:    return {29'b0, m_cfg};
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] a);
      case (a)
         3'd0:    return "R1 status read";
         3'd1:    return "R4 mask read";
         3'd5:    return "R9 control read";
         3'd6:    return "R10 cfg status read";
         default: return "R7 zero read";
      endcase
   endfunction

   task automatic model_reset();
      m_st = '0; m_mk = '1; m_ctl = '0; m_cfg = 3'b001; m_irq = 1'b0;
   endtask

   task automatic step(input logic wr, input logic [2:0] a, input logic [DW-1:0] d,
                       input logic [N-1:0] ev);
      reg_wr = wr; reg_addr = a; reg_wdata = d; hw_event = ev;
      @(posedge clk);
      m_irq = |(m_st & ~m_mk);
      if (wr) begin
         case (a)
            3'd0: m_st = m_st & ~d[N-1:0];
            3'd2: m_mk = m_mk & ~d[N-1:0];
            3'd3: m_mk = m_mk | d[N-1:0];
            3'd4: m_st = m_st | d[N-1:0];
            3'd5: begin
               m_ctl = d[14:0];
               if (d[0]) m_cfg = m_cfg | 3'b110;
            end
            default: ;
         endcase
      end
      m_st = m_st | ev;
      @(negedge clk);
      reg_wr = 1'b0; hw_event = '0;
      chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
   endtask

   task automatic rd(input string req, input logic [2:0] a);
      reg_wr = 1'b0; hw_event = '0; reg_addr = a;
      #1;
      chk(req, reg_rdata, exp_read(a));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240517));
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; hw_event = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R8 irq after reset", {31'b0, irq}, 32'd0);
      for (int a = 0; a < 8; a++) rd(req_of(3'(a)), 3'(a));

      // R4: direct mask write ignored
      step(1'b1, 3'd1, 32'h0000_0000, '0);
      rd("R4 mask write ignored", 3'd1);
      // R3: force sets causes; still masked
      step(1'b1, 3'd4, 32'h0000_0005, '0);
      rd("R3 force sets status", 3'd0);
      rd("R7 force reads zero", 3'd4);
      // R5: unmask bit 0, irq follows a cycle later
      step(1'b1, 3'd2, 32'h0000_0001, '0);
      rd("R5 unmask", 3'd1);
      step(1'b0, 3'd0, '0, '0);
      chk("R8 irq raised", {31'b0, irq}, 32'd1);
      // R2: clear bits 0 and 2 while event hits bit 2
      step(1'b1, 3'd0, 32'h0000_0005, 10'h004);
      rd("R2 event beats clear", 3'd0);
      step(1'b0, 3'd0, '0, '0);
      chk("R8 irq dropped", {31'b0, irq}, 32'd0);
      // R6: mask everything
      step(1'b1, 3'd3, 32'h0000_03FF, '0);
      rd("R6 mask all", 3'd1);
      // R1: reserved force bits ignored
      step(1'b1, 3'd4, 32'hFFFF_FC00, '0);
      rd("R1 reserved bits stay zero", 3'd0);
      // R9: control without scan bit, then with
      step(1'b1, 3'd5, 32'h0000_0002, '0);
      rd("R9 no scan", 3'd6);
      rd("R9 control readback", 3'd5);
      step(1'b1, 3'd5, 32'hFFFF_7FFF, '0);
      rd("R9 scan flags", 3'd6);
      rd("R9 control width", 3'd5);

      for (int i = 0; i < 4000; i++) begin
         logic [2:0]    a;
         logic [DW-1:0] d;
         logic [N-1:0]  ev;
         logic          w;
         a  = 3'($urandom % 8);
         d  = $urandom;
         w  = ($urandom % 4) != 0;
         ev = (($urandom % 6) == 0) ? N'($urandom) : '0;
         if (a == 3'd5 && ($urandom % 3) != 0) d[0] = 1'b0;
         step(w, a, d, ev);
         rd(req_of(3'(i % 8)), 3'(i % 8));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule